// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a down-counting watchdog that raises an internal reset request when its programmed period runs out before software services it. Software reaches it through a small byte-wide register port: a write strobe, a 2-bit register select and an 8-bit data byte. One register holds the mode bit, two hold the 16-bit reload period, and the fourth is the service register. The counter steps down once for every cycle in which the `tick` input is high.

Servicing needs two bytes written to the service register in a fixed order: AAh first, then 55h. A single write of either byte does nothing. When the count is at zero and a tick arrives, the block sends a one-clock pulse on `rst_req` to the chip's reset manager and reloads the period. The request goes only to internal reset logic. No external reset pin exists on this block, so it cannot drive one.

Top module: `wdog_keyed`

## Requirements
- R1: After `rst_n` is released, `wd_count` and the reload register both equal the parameter `RELOAD_INIT`. The mode bit is 1, so the watchdog is off, and `rst_req` is low.
- R2: Register select 0 is the control register. Its bit 0 is an active-low enable: 0 turns the watchdog on and 1 turns it off. The other data bits are ignored.
- R3: While the watchdog is on and no service completes, a cycle with `tick` high and a nonzero count lowers `wd_count` by one in the next cycle. A cycle with `tick` low leaves the count unchanged.
- R4: While the watchdog is on, a cycle with `tick` high and a count of zero makes `rst_req` high for exactly the next cycle. In that same cycle `wd_count` equals the reload value. With a reload value of zero, every tick produces a request.
- R5: While the watchdog is off, ticks do not change `wd_count` and `rst_req` stays low.
- R6: Register select 3 is the service register. Writing AAh there, followed by 55h as the next write to that register, loads `wd_count` from the reload register in the cycle after the 55h write. Writes to other registers in between do not break the sequence. The load works whether the watchdog is on or off. It also takes priority over a tick in the same cycle, so no request is raised then.
- R7: A 55h write to the service register that does not directly follow an AAh write there leaves `wd_count` unchanged. The same applies when any byte other than 55h follows AAh; that write also clears the pending sequence. A later AAh starts a new sequence, and AAh followed by AAh and then 55h completes one.
- R8: Register select 1 writes the low byte of the reload register and select 2 writes the high byte. A new reload value is used only at the next service or expiry reload. The current count is not changed by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 reload low, 2 reload high, 3 service |
| wr_data | input | 8 | Write data byte |
| tick | input | 1 | Count enable, one step per cycle high |
| wd_count | output | 16 | Current watchdog count |
| rst_req | output | 1 | One-clock internal reset request |

## Verification
The embedded properties assume that a request can only follow a tick taken at a zero count, and that a write is seen in one clock cycle. They also assume `wr_en` is a one-cycle strobe, so each service byte is one write. The stimulus drives every input at the falling edge and holds each write for a single cycle. The bench's reference model gets the same inputs at each rising edge and is compared with both outputs on every clock. Key sequences are interleaved with writes to other registers, with stray bytes, and with ticks that land in the same cycle as a service.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter logic [15:0] RELOAD_INIT = 16'hFFFF,
  parameter logic [7:0]  KEY_A       = 8'hAA,
  parameter logic [7:0]  KEY_B       = 8'h55
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        tick,
  output logic [15:0] wd_count,
  output logic        rst_req
);

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_RLO = 2'd1;
  localparam logic [1:0] SEL_RHI = 2'd2;
  localparam logic [1:0] SEL_KEY = 2'd3;

  logic        dis_q;
  logic        armed_q;
  logic [15:0] rel_q;
  logic [15:0] cnt_q;
  logic        req_q;

  wire key_wr  = wr_en && wr_addr == SEL_KEY;
  wire svc_hit = key_wr && wr_data == KEY_B && armed_q;
  wire step    = !dis_q && tick && !svc_hit;
  wire expire  = step && cnt_q == 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      rel_q   <= RELOAD_INIT;
      cnt_q   <= RELOAD_INIT;
      req_q   <= 1'b0;
    end else begin
      req_q <= expire;
      if (svc_hit || expire) cnt_q <= rel_q;
      else if (step)         cnt_q <= cnt_q - 16'd1;
      if (key_wr) armed_q <= (wr_data == KEY_A);
      if (wr_en && wr_addr == SEL_CTL) dis_q <= wr_data[0];
      if (wr_en && wr_addr == SEL_RLO) rel_q[7:0]  <= wr_data;
      if (wr_en && wr_addr == SEL_RHI) rel_q[15:8] <= wr_data;
    end
  end

  assign wd_count = cnt_q;
  assign rst_req  = req_q;

  assert_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(!dis_q && tick && cnt_q == 16'd0));
  assert_reload_on_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wd_count == $past(rel_q));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_q && tick && !svc_hit && cnt_q != 16'd0) |=> wd_count == $past(cnt_q) - 16'd1);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q && !svc_hit) |=> (wd_count == $past(cnt_q) && !rst_req));
  assert_service_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |=> (wd_count == $past(rel_q) && !rst_req));
  assert_stray_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_KEY && wr_data != KEY_A) |=> !armed_q);

endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic        tick = 1'b0;
  logic [15:0] wd_count;
  logic        rst_req;

  wdog_keyed u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .tick(tick), .wd_count(wd_count), .rst_req(rst_req));

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string phase = "R1";

  int m_cnt = 16'hFFFF;
  int m_rel = 16'hFFFF;
  bit m_off = 1'b1;
  bit m_arm = 1'b0;
  bit m_req = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_rel = 16'hFFFF; m_off = 1; m_arm = 0; m_req = 0;
    end else begin
      bit svc;
      bit req_n;
      req_n = 0;
      svc = wr_en && wr_addr == 2'd3 && wr_data == 8'h55 && m_arm;
      if (wr_en && wr_addr == 2'd3) m_arm = (wr_data == 8'hAA);
      if (svc) m_cnt = m_rel;
      else if (!m_off && tick) begin
        if (m_cnt == 0) begin req_n = 1; m_cnt = m_rel; end
        else m_cnt = m_cnt - 1;
      end
      if (wr_en && wr_addr == 2'd0) m_off = wr_data[0];
      if (wr_en && wr_addr == 2'd1) m_rel = (m_rel & 16'hFF00) | wr_data;
      if (wr_en && wr_addr == 2'd2) m_rel = (m_rel & 16'h00FF) | (int'(wr_data) << 8);
      m_req = req_n;
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({phase, " count"}, wd_count, m_cnt);
      check({phase, " rst_req"}, rst_req, m_req);
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    check("R1 reset count", wd_count, 16'hFFFF);
    check("R1 reset req", rst_req, 0);

    phase = "R5"; tick = 1; idle(20);
    check("R5 disabled hold", wd_count, 16'hFFFF);

    phase = "R8";
    wr(2'd1, 8'd5); wr(2'd2, 8'd0);
    check("R8 count untouched by reload write", wd_count, 16'hFFFF);

    phase = "R6";
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55);
    check("R6 service while off", wd_count, 5);

    phase = "R2";
    wr(2'd0, 8'hFE);
    idle(3);
    phase = "R4"; idle(20);

    phase = "R3";
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); tick = (i % 3 == 0);
    end

    phase = "R6"; tick = 1;
    wr(2'd3, 8'hAA); wr(2'd1, 8'd9); wr(2'd3, 8'h55);
    idle(15);

    phase = "R7";
    tick = 0;
    wr(2'd1, 8'd40);
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55);
    check("R7 baseline service to 40", wd_count, 40);
    tick = 1; idle(4); tick = 0;
    wr(2'd3, 8'h55);
    check("R7 lone key B ignored", wd_count, 36);
    wr(2'd3, 8'hAA); wr(2'd3, 8'h12); wr(2'd3, 8'h55);
    check("R7 stray byte breaks sequence", wd_count, 36);
    wr(2'd3, 8'hAA); wr(2'd3, 8'hAA); wr(2'd3, 8'h55);
    check("R7 AA AA 55 completes", wd_count, 40);

    phase = "R4";
    wr(2'd1, 8'd0);
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55);
    tick = 1; idle(6);

    phase = "R5";
    wr(2'd1, 8'd7);
    wr(2'd3, 8'hAA); wr(2'd3, 8'h55);
    idle(3);
    wr(2'd0, 8'h01);
    idle(10);
    check("R5 off after disable", rst_req, 0);

    phase = "R2";
    wr(2'd0, 8'hF0);
    idle(25);
    tick = 0;
    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule